// File: doc/BRIEF.md
# Reorder Buffer with Register Rename Table

This block keeps a small circular buffer of in-flight results and a rename table for the architectural floating-point registers. When an instruction is dispatched, the block takes the slot at the tail. It stores the destination register and the number of the reservation station that will produce the value. It then points the destination's rename entry at that slot. In the same cycle it reports, for each of two source registers, either a ready value or the slot tag to wait on.

Results arrive on a broadcast port addressed by slot tag. The slot latches the value, so the producing station can be released at once. Only the oldest slot (the head) may retire. When it holds a result, the block writes the value into the architectural register file that it contains, and it shows the retirement on the commit outputs. A younger result that finished early stays in its slot until every older slot has retired. The register file therefore always matches a precise point in program order.

Occupancy is tracked by a three-state machine:
- `OCC_EMPTY` moves to `OCC_PARTIAL` on the first allocation, or to `OCC_FULL` when the buffer has a single slot.
- `OCC_PARTIAL` moves to `OCC_EMPTY` when it drains and to `OCC_FULL` when it fills.
- `OCC_FULL` moves back on release, which is a retirement. It goes to `OCC_EMPTY` only when the buffer has a single slot.

Allocation while in `OCC_FULL` is refused.

Top module: `reorder_rename_unit`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `commit_valid` is 0, and every register k is reported ready with value k.
- R2: Accepted dispatches take slots in index order 0,1,2,3,0,… `disp_tag` shows the slot that an accepted dispatch receives.
- R3: `disp_ready` is 0 exactly while all four slots are busy. A dispatch offered then changes neither the pointers nor the rename table.
- R4: A source register with no pending producer is reported ready with the register-file value.
- R5: A source register mapped to an incomplete slot is reported not ready, with that slot's index as tag. If a broadcast for that slot occurs in the same cycle, the source is reported ready with the broadcast value.
- R6: A broadcast to a busy, incomplete slot latches its value. Later lookups of a register mapped to that slot report it ready with that value, with no further broadcast.
- R7: `commit_valid` is 1 only when the head slot is busy and complete. A complete younger slot never retires ahead of an incomplete older one.
- R8: On retirement, `commit_reg`, `commit_value` and `commit_station` show the head slot's destination, latched value and producing station. The register file takes that value at the clock edge.
- R9: On retirement, the register's rename entry is cleared only if it still names the retiring slot. A newer mapping, including one made by a dispatch in the same cycle, is kept.
- R10: A slot freed by retirement is offered for dispatch in the next cycle, so a full buffer raises `disp_ready` one cycle after a retirement.
- R11: Source lookups in a dispatch cycle use the mapping held before that dispatch. A source equal to the destination reports the previous producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_dest | input | 3 | Destination architectural register |
| disp_station | input | 3 | Reservation station that will produce the result |
| disp_ready | output | 1 | A slot is free; a dispatch is accepted |
| disp_tag | output | 2 | Slot given to an accepted dispatch |
| src_a_reg | input | 3 | First source register to look up |
| src_a_ready | output | 1 | First source value is available |
| src_a_tag | output | 2 | Slot to wait on when not ready |
| src_a_value | output | 16 | First source value when ready |
| src_b_reg | input | 3 | Second source register to look up |
| src_b_ready | output | 1 | Second source value is available |
| src_b_tag | output | 2 | Slot to wait on when not ready |
| src_b_value | output | 16 | Second source value when ready |
| bcast_valid | input | 1 | Result broadcast this cycle |
| bcast_tag | input | 2 | Slot the broadcast result belongs to |
| bcast_value | input | 16 | Broadcast result value |
| commit_valid | output | 1 | Head slot retires at this clock edge |
| commit_reg | output | 3 | Register written by the retirement |
| commit_value | output | 16 | Value written by the retirement |
| commit_station | output | 3 | Station that produced the retiring value |

## Verification
Dispatch and retirement fall in the same cycle constantly. The bench provokes the hard case directly by dispatching to the very register that the head is retiring, and it judges the result with the lookups of the next cycle. Those lookups must still see the new producer (R9), while the register file already holds the retired value. Broadcast and source lookup also coincide: every cycle the bench sweeps all registers through both lookup ports while a broadcast is on the bus. Its own model decides, for each register, whether the answer is a latched value, the value just broadcast, or a tag.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;
endpackage

// File: rtl/rob_occupancy_fsm.sv
`timescale 1ns/1ps
module rob_occupancy_fsm
    import rob_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic          retire,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    occ_state_e    state, state_nxt;
    logic [CW-1:0] count_nxt;
    logic [PW-1:0] head_nxt, tail_nxt;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        count_nxt = count + CW'(alloc) - CW'(retire);
        head_nxt  = retire ? wrap_inc(head) : head;
        tail_nxt  = alloc  ? wrap_inc(tail) : tail;
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: begin
                // first allocation
                if (alloc)
                    state_nxt = (count_nxt == CW'(DEPTH)) ? OCC_FULL : OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                // drain or fill
                if (count_nxt == '0)
                    state_nxt = OCC_EMPTY;
                else if (count_nxt == CW'(DEPTH))
                    state_nxt = OCC_FULL;
            end
            OCC_FULL: begin
                // release
                if (retire)
                    state_nxt = (count_nxt == '0) ? OCC_EMPTY : OCC_PARTIAL;
            end
            default: state_nxt = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            count <= '0;
            head  <= '0;
            tail  <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
            head  <= head_nxt;
            tail  <= tail_nxt;
        end
    end

    always_comb begin
        full  = (state == OCC_FULL);
        empty = (state == OCC_EMPTY);
    end
endmodule

// File: rtl/rob_entry_array.sv
`timescale 1ns/1ps
module rob_entry_array #(
    parameter int DEPTH = 4,
    parameter int RW    = 3,
    parameter int SW    = 3,
    parameter int DW    = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc,
    input  logic [PW-1:0]             alloc_idx,
    input  logic [RW-1:0]             alloc_dest,
    input  logic [SW-1:0]             alloc_stn,
    input  logic                      bc_valid,
    input  logic [PW-1:0]             bc_idx,
    input  logic [DW-1:0]             bc_value,
    input  logic                      retire,
    input  logic [PW-1:0]             retire_idx,
    output logic [DEPTH-1:0]          busy_vec,
    output logic [DEPTH-1:0]          done_vec,
    output logic [DEPTH-1:0][RW-1:0]  dest_vec,
    output logic [DEPTH-1:0][SW-1:0]  stn_vec,
    output logic [DEPTH-1:0][DW-1:0]  value_vec
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic          busy_q, done_q;
        logic [RW-1:0] dest_q;
        logic [SW-1:0] stn_q;
        logic [DW-1:0] value_q;
        logic          hit_alloc, hit_retire, hit_bc;

        always_comb begin
            hit_alloc  = alloc    && (alloc_idx  == PW'(g));
            hit_retire = retire   && (retire_idx == PW'(g));
            hit_bc     = bc_valid && (bc_idx     == PW'(g)) && busy_q && !done_q;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q  <= 1'b0;
                done_q  <= 1'b0;
                dest_q  <= '0;
                stn_q   <= '0;
                value_q <= '0;
            end else if (hit_alloc) begin
                busy_q <= 1'b1;
                done_q <= 1'b0;
                dest_q <= alloc_dest;
                stn_q  <= alloc_stn;
            end else if (hit_retire) begin
                busy_q <= 1'b0;
                done_q <= 1'b0;
            end else if (hit_bc) begin
                done_q  <= 1'b1;
                value_q <= bc_value;
            end
        end

        assign busy_vec[g]  = busy_q;
        assign done_vec[g]  = done_q;
        assign dest_vec[g]  = dest_q;
        assign stn_vec[g]   = stn_q;
        assign value_vec[g] = value_q;
    end
endmodule

// File: rtl/rob_rename_table.sv
`timescale 1ns/1ps
module rob_rename_table #(
    parameter int NREG  = 8,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int RW = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc,
    input  logic [RW-1:0]            alloc_dest,
    input  logic [PW-1:0]            alloc_idx,
    input  logic                     retire,
    input  logic [PW-1:0]            retire_idx,
    input  logic [RW-1:0]            retire_dest,
    input  logic [DW-1:0]            retire_value,
    output logic [NREG-1:0]          map_valid,
    output logic [NREG-1:0][PW-1:0]  map_tag,
    output logic [NREG-1:0][DW-1:0]  rf_value
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic          mv_q;
        logic [PW-1:0] mt_q;
        logic [DW-1:0] rf_q;
        logic          wr_new, wr_ret;

        always_comb begin
            wr_new = alloc  && (alloc_dest  == RW'(g));
            wr_ret = retire && (retire_dest == RW'(g));
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mv_q <= 1'b0;
                mt_q <= '0;
                rf_q <= DW'(g);
            end else begin
                if (wr_ret)
                    rf_q <= retire_value;
                if (wr_new) begin
                    mv_q <= 1'b1;
                    mt_q <= alloc_idx;
                end else if (wr_ret && mv_q && (mt_q == retire_idx)) begin
                    mv_q <= 1'b0;
                end
            end
        end

        assign map_valid[g] = mv_q;
        assign map_tag[g]   = mt_q;
        assign rf_value[g]  = rf_q;
    end
endmodule

// File: rtl/rob_src_lookup.sv
`timescale 1ns/1ps
module rob_src_lookup #(
    parameter int NREG  = 8,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int RW = $clog2(NREG)
) (
    input  logic [RW-1:0]             src_reg,
    input  logic [NREG-1:0]           map_valid,
    input  logic [NREG-1:0][PW-1:0]   map_tag,
    input  logic [NREG-1:0][DW-1:0]   rf_value,
    input  logic [DEPTH-1:0]          done_vec,
    input  logic [DEPTH-1:0][DW-1:0]  value_vec,
    input  logic                      bc_valid,
    input  logic [PW-1:0]             bc_idx,
    input  logic [DW-1:0]             bc_value,
    output logic                      ready,
    output logic [PW-1:0]             tag,
    output logic [DW-1:0]             value
);
    logic [PW-1:0] slot;

    always_comb begin
        slot  = map_tag[src_reg];
        ready = 1'b1;
        tag   = '0;
        value = rf_value[src_reg];
        if (map_valid[src_reg]) begin
            tag = slot;
            if (done_vec[slot]) begin
                value = value_vec[slot];
            end else if (bc_valid && (bc_idx == slot)) begin
                value = bc_value;
            end else begin
                ready = 1'b0;
                value = '0;
            end
        end
    end
endmodule

// File: rtl/reorder_rename_unit.sv
`timescale 1ns/1ps
module reorder_rename_unit #(
    parameter int DEPTH = 4,
    parameter int NREG  = 8,
    parameter int DW    = 16,
    parameter int SW    = 3,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int RW = $clog2(NREG),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disp_valid,
    input  logic [RW-1:0] disp_dest,
    input  logic [SW-1:0] disp_station,
    output logic          disp_ready,
    output logic [PW-1:0] disp_tag,
    input  logic [RW-1:0] src_a_reg,
    output logic          src_a_ready,
    output logic [PW-1:0] src_a_tag,
    output logic [DW-1:0] src_a_value,
    input  logic [RW-1:0] src_b_reg,
    output logic          src_b_ready,
    output logic [PW-1:0] src_b_tag,
    output logic [DW-1:0] src_b_value,
    input  logic          bcast_valid,
    input  logic [PW-1:0] bcast_tag,
    input  logic [DW-1:0] bcast_value,
    output logic          commit_valid,
    output logic [RW-1:0] commit_reg,
    output logic [DW-1:0] commit_value,
    output logic [SW-1:0] commit_station
);
    localparam int NSRC = 2;

    logic [PW-1:0] head_ptr, tail_ptr;
    logic [CW-1:0] occ_count;
    logic          occ_full, occ_empty;
    logic          do_alloc, do_retire;

    logic [DEPTH-1:0]          busy_vec, done_vec;
    logic [DEPTH-1:0][RW-1:0]  dest_vec;
    logic [DEPTH-1:0][SW-1:0]  stn_vec;
    logic [DEPTH-1:0][DW-1:0]  value_vec;

    logic [NREG-1:0]           map_valid;
    logic [NREG-1:0][PW-1:0]   map_tag;
    logic [NREG-1:0][DW-1:0]   rf_value;

    logic [NSRC-1:0][RW-1:0]   src_regs;
    logic [NSRC-1:0]           src_rdy;
    logic [NSRC-1:0][PW-1:0]   src_tags;
    logic [NSRC-1:0][DW-1:0]   src_vals;

    always_comb begin
        do_alloc  = disp_valid && !occ_full;
        do_retire = busy_vec[head_ptr] && done_vec[head_ptr];
    end

    rob_occupancy_fsm #(.DEPTH(DEPTH)) u_occ (
        .clk    (clk),
        .rst_n  (rst_n),
        .alloc  (do_alloc),
        .retire (do_retire),
        .head   (head_ptr),
        .tail   (tail_ptr),
        .count  (occ_count),
        .full   (occ_full),
        .empty  (occ_empty)
    );

    rob_entry_array #(.DEPTH(DEPTH), .RW(RW), .SW(SW), .DW(DW)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (do_alloc),
        .alloc_idx  (tail_ptr),
        .alloc_dest (disp_dest),
        .alloc_stn  (disp_station),
        .bc_valid   (bcast_valid),
        .bc_idx     (bcast_tag),
        .bc_value   (bcast_value),
        .retire     (do_retire),
        .retire_idx (head_ptr),
        .busy_vec   (busy_vec),
        .done_vec   (done_vec),
        .dest_vec   (dest_vec),
        .stn_vec    (stn_vec),
        .value_vec  (value_vec)
    );

    rob_rename_table #(.NREG(NREG), .DEPTH(DEPTH), .DW(DW)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc        (do_alloc),
        .alloc_dest   (disp_dest),
        .alloc_idx    (tail_ptr),
        .retire       (do_retire),
        .retire_idx   (head_ptr),
        .retire_dest  (dest_vec[head_ptr]),
        .retire_value (value_vec[head_ptr]),
        .map_valid    (map_valid),
        .map_tag      (map_tag),
        .rf_value     (rf_value)
    );

    assign src_regs[0] = src_a_reg;
    assign src_regs[1] = src_b_reg;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        rob_src_lookup #(.NREG(NREG), .DEPTH(DEPTH), .DW(DW)) u_look (
            .src_reg   (src_regs[s]),
            .map_valid (map_valid),
            .map_tag   (map_tag),
            .rf_value  (rf_value),
            .done_vec  (done_vec),
            .value_vec (value_vec),
            .bc_valid  (bcast_valid),
            .bc_idx    (bcast_tag),
            .bc_value  (bcast_value),
            .ready     (src_rdy[s]),
            .tag       (src_tags[s]),
            .value     (src_vals[s])
        );
    end

    always_comb begin
        disp_ready     = !occ_full;
        disp_tag       = tail_ptr;
        src_a_ready    = src_rdy[0];
        src_a_tag      = src_tags[0];
        src_a_value    = src_vals[0];
        src_b_ready    = src_rdy[1];
        src_b_tag      = src_tags[1];
        src_b_value    = src_vals[1];
        commit_valid   = do_retire;
        commit_reg     = dest_vec[head_ptr];
        commit_value   = value_vec[head_ptr];
        commit_station = stn_vec[head_ptr];
    end
endmodule

// File: rtl/reorder_rename_chk.sv
`timescale 1ns/1ps
module reorder_rename_chk #(
    parameter int DEPTH = 4,
    parameter int NREG  = 8,
    parameter int DW    = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int RW = $clog2(NREG),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    disp_valid,
    input logic                    disp_ready,
    input logic                    commit_valid,
    input logic [RW-1:0]           commit_reg,
    input logic [DW-1:0]           commit_value,
    input logic [PW-1:0]           head,
    input logic [PW-1:0]           tail,
    input logic [CW-1:0]           count,
    input logic [NREG-1:0][DW-1:0] rf_value
);
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> !disp_ready);

    // R3
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3
    blocked_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready && !commit_valid) |=> $stable(tail) && $stable(count));

    // R2
    tail_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=>
            (tail == PW'((32'($past(tail)) + 1) % DEPTH)));

    // R7
    head_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> (head == PW'((32'($past(head)) + 1) % DEPTH)));

    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_valid |=> $stable(head));

    // R8
    rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> (rf_value[$past(commit_reg)] == $past(commit_value)));
endmodule

bind reorder_rename_unit reorder_rename_chk #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_valid   (disp_valid),
    .disp_ready   (disp_ready),
    .commit_valid (commit_valid),
    .commit_reg   (commit_reg),
    .commit_value (commit_value),
    .head         (head_ptr),
    .tail         (tail_ptr),
    .count        (occ_count),
    .rf_value     (rf_value)
);

// File: tb/test_reorder_rename_unit.sv
`timescale 1ns/1ps
module test_reorder_rename_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int NREG  = 8;
    localparam int DW    = 16;
    localparam int SW    = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       disp_valid;
    logic [2:0] disp_dest, disp_station;
    logic       disp_ready;
    logic [1:0] disp_tag;
    logic [2:0] src_a_reg, src_b_reg;
    logic       src_a_ready, src_b_ready;
    logic [1:0] src_a_tag, src_b_tag;
    logic [15:0] src_a_value, src_b_value;
    logic       bcast_valid;
    logic [1:0] bcast_tag;
    logic [15:0] bcast_value;
    logic       commit_valid;
    logic [2:0] commit_reg, commit_station;
    logic [15:0] commit_value;

    int n_checks = 0;
    int n_fail   = 0;

    int m_busy[DEPTH], m_done[DEPTH], m_dest[DEPTH], m_stn[DEPTH], m_val[DEPTH];
    int m_mapv[NREG], m_mapt[NREG], m_rf[NREG];
    int m_head, m_tail, m_cnt;
    int prev_commit_dest = -1;
    int prev_full_commit = 0;
    int unsigned seed = 32'h2F6E_91A3;

    reorder_rename_unit #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW), .SW(SW)) i_reorder_rename_unit (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_station(disp_station),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .src_a_reg(src_a_reg), .src_a_ready(src_a_ready), .src_a_tag(src_a_tag), .src_a_value(src_a_value),
        .src_b_reg(src_b_reg), .src_b_ready(src_b_ready), .src_b_tag(src_b_tag), .src_b_value(src_b_value),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_value(bcast_value),
        .commit_valid(commit_valid), .commit_reg(commit_reg), .commit_value(commit_value),
        .commit_station(commit_station)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected lookup result from the model (pre-edge state), labelled by requirement.
    task automatic check_lookup(input string ovr, input int r, input int rdy, input int tg, input int val);
        string req;
        int er, ev, t;
        er = 1; ev = m_rf[r]; t = m_mapt[r];
        if (!m_mapv[r]) req = "R4";
        else if (m_done[t]) begin req = "R6"; ev = m_val[t]; end
        else if (bcast_valid && int'(bcast_tag) == t) begin req = "R5"; ev = int'(bcast_value); end
        else begin req = "R5"; er = 0; end
        if (r == prev_commit_dest) req = "R9";
        if (disp_valid && disp_ready && int'(disp_dest) == r) req = "R11";
        if (ovr != "") req = ovr;
        check(req, $sformatf("ready of r%0d", r), rdy, er);
        if (er) check(req, $sformatf("value of r%0d", r), val, ev);
        else    check(req, $sformatf("tag of r%0d", r), tg, t);
    endtask

    task automatic step(input int dv, input int dd, input int ds,
                        input int bv, input int bt, input int bval);
        int acc, ret, h, t, d;
        @(negedge clk);
        disp_valid   = dv[0];
        disp_dest    = dd[2:0];
        disp_station = ds[2:0];
        bcast_valid  = bv[0];
        bcast_tag    = bt[1:0];
        bcast_value  = bval[15:0];
        #1;
        check(prev_full_commit ? "R10" : "R3", "disp_ready", int'(disp_ready), int'(m_cnt < DEPTH));
        if (m_cnt < DEPTH) check("R2", "disp_tag", int'(disp_tag), m_tail);
        h = m_head;
        ret = m_busy[h] && m_done[h];
        check("R7", "commit_valid", int'(commit_valid), ret);
        if (ret) begin
            check("R8", "commit_reg", int'(commit_reg), m_dest[h]);
            check("R8", "commit_value", int'(commit_value), m_val[h]);
            check("R8", "commit_station", int'(commit_station), m_stn[h]);
        end
        for (int r = 0; r < NREG; r++) begin
            src_a_reg = r[2:0];
            src_b_reg = 3'(NREG - 1 - r);
            #0.4;
            check_lookup("", r, int'(src_a_ready), int'(src_a_tag), int'(src_a_value));
            check_lookup("", NREG - 1 - r, int'(src_b_ready), int'(src_b_tag), int'(src_b_value));
        end
        // model update at the coming edge
        acc = dv && (m_cnt < DEPTH);
        t = m_tail;
        prev_full_commit = ret && (m_cnt == DEPTH);
        prev_commit_dest = ret ? m_dest[h] : -1;
        if (bv && m_busy[bt] && !m_done[bt]) begin
            m_done[bt] = 1;
            m_val[bt]  = bval & 16'hFFFF;
        end
        if (ret) begin
            d = m_dest[h];
            m_rf[d] = m_val[h];
            m_busy[h] = 0;
            m_done[h] = 0;
            if (m_mapv[d] && m_mapt[d] == h && !(acc && dd == d)) m_mapv[d] = 0;
            m_head = (h + 1) % DEPTH;
            m_cnt--;
        end
        if (acc) begin
            m_busy[t] = 1; m_done[t] = 0; m_dest[t] = dd; m_stn[t] = ds;
            m_mapv[dd] = 1; m_mapt[dd] = t;
            m_tail = (t + 1) % DEPTH;
            m_cnt++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        disp_valid = 0; disp_dest = 0; disp_station = 0;
        src_a_reg = 0; src_b_reg = 0;
        bcast_valid = 0; bcast_tag = 0; bcast_value = 0;
        for (int i = 0; i < DEPTH; i++) begin
            m_busy[i] = 0; m_done[i] = 0; m_dest[i] = 0; m_stn[i] = 0; m_val[i] = 0;
        end
        for (int r = 0; r < NREG; r++) begin
            m_mapv[r] = 0; m_mapt[r] = 0; m_rf[r] = r;
        end
        m_head = 0; m_tail = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", "disp_ready after reset", int'(disp_ready), 1);
        check("R1", "commit_valid after reset", int'(commit_valid), 0);
        for (int r = 0; r < NREG; r++) begin
            src_a_reg = r[2:0];
            #0.2;
            check_lookup("R1", r, int'(src_a_ready), int'(src_a_tag), int'(src_a_value));
        end

        // fill: r1, r2, r1 again (newer producer), r3 -> full
        step(1, 1, 1, 0, 0, 0);
        step(1, 2, 2, 0, 0, 0);
        step(1, 1, 3, 0, 0, 0);
        step(1, 3, 4, 0, 0, 0);
        // R3 dispatch while full is refused
        step(1, 5, 5, 0, 0, 0);
        @(negedge clk);
        disp_valid = 0; bcast_valid = 0;
        src_a_reg = 3'd5;
        #1;
        check_lookup("R3", 5, int'(src_a_ready), int'(src_a_tag), int'(src_a_value));
        // R7 younger slot completes first; must not retire
        step(0, 0, 0, 1, 2, 16'h0222);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 3, 16'h0333);
        // oldest completes, then retires; r1 keeps newer mapping (R9)
        step(0, 0, 0, 1, 0, 16'h0111);
        step(0, 0, 0, 0, 0, 0);
        // R10 slot reopened; dispatch to r2 while slot 1 (r2) completes and retires later
        step(1, 2, 6, 1, 1, 16'h0444);
        step(1, 2, 7, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        repeat (4) step(0, 0, 0, 0, 0, 0);

        // pseudo-random sweep
        for (int c = 0; c < 4000; c++) begin
            int dv, bv, bt, st;
            dv = (rnd() % 8) < 5;
            bv = 0; bt = 0;
            if ((rnd() % 4) != 0) begin
                st = rnd() % DEPTH;
                for (int k = 0; k < DEPTH; k++) begin
                    int e;
                    e = (st + k) % DEPTH;
                    if (!bv && m_busy[e] && !m_done[e]) begin bv = 1; bt = e; end
                end
            end
            step(dv, rnd() % NREG, rnd() % 8, bv, bt, rnd() % 65536);
        end
        repeat (8) step(0, 0, 0, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule